// File: doc/BRIEF.md
# PTP target time trigger unit

This block holds an alarm time for a precision time protocol clock, made of whole seconds and nanoseconds. Software writes the alarm through a small register port in the register clock domain and then issues an arm command. The arm command sends the alarm across to the PTP clock domain through a toggle handshake, and a busy flag is visible while the transfer is under way. Once armed, the PTP side compares the running timestamp with the alarm. The test is "at or past", so an increment that jumps over the exact value still causes a trigger.

On a trigger, a two-bit action field chosen at arm time has one of three effects: it turns the pulse-per-second enable output on, turns it off, or leaves it as it is. Every trigger also sets a sticky status bit in the register domain. The interrupt output is that bit gated by an enable. Each arm fires exactly once. A new arm replaces any alarm that is still pending.

Top module: `ptp_tgt_trigger`

## Requirements
- R1: After reset every register reads zero, `pps_o` is 0 and `irq_o` is 0.
- R2: Address 1 holds the 32-bit alarm seconds. Address 2 holds the alarm nanoseconds in bits 30:0. Both are read-write. Bit 31 of address 2 is the read-only busy flag.
- R3: With `ROLL_DIGITAL`=1, a write to address 2 whose bits 30:0 exceed 999,999,999 leaves the stored nanoseconds unchanged.
- R4: Address 0 holds the command in bits 3:0, the action in bits 6:5 and the interrupt enable in bit 8. A write with command 4'b0010 or 4'b0011 arms the unit and makes busy read 1 in the next cycle. Any other command value does not set busy. The command bits always read 0.
- R5: Busy clears when the acknowledge toggle returns to the register domain. When both clocks are the same clock, busy reads 1 for exactly 5 cycles after the arm write.
- R6: While busy is 1, writes to addresses 0, 1 and 2 are ignored.
- R7: An armed unit triggers on the first PTP edge where the timestamp seconds are greater than the alarm seconds, or the seconds are equal and the timestamp nanoseconds are at least the alarm nanoseconds. It triggers only once per arm.
- R8: On a trigger, action 2'b10 sets `pps_o` to 1 and action 2'b11 clears it, both on the triggering PTP edge. Actions 2'b00 and 2'b01 leave `pps_o` unchanged.
- R9: Every trigger sets status bit 0 at address 3 three register clocks after the triggering edge. `irq_o` equals that status bit ANDed with the enable bit 8 of address 0.
- R10: Writing 1 to bit 0 of address 3 clears the status bit. If a trigger sets the bit in the same cycle, the set takes priority.
- R11: Arming again before a trigger replaces the pending alarm and action. The earlier alarm then never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| ptp_clk_i | input | 1 | PTP domain clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ts_sec_i | input | 32 | Running timestamp, seconds (PTP domain) |
| ts_ns_i | input | 31 | Running timestamp, nanoseconds (PTP domain) |
| pps_o | output | 1 | Pulse-per-second enable (PTP domain) |
| irq_o | output | 1 | Masked interrupt (register domain) |

## Verification
The collision of interest is a software clear of the sticky status bit landing in the same register cycle as a synchronized trigger that sets it. The bench uses its own reference model to find the trigger's arrival. It then drives the write-1-to-clear so that it is sampled on exactly that edge, and expects the status bit and `irq_o` to stay at 1. Triggers come from timestamps advancing by fractional steps (7.25 ns and 3.33 ns), which step over the exact alarm value. The triggering edge and the `pps_o` change are compared cycle by cycle against the model.

// File: rtl/ptt_pkg.sv
`timescale 1ns/1ps
package ptt_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_SEC  = 2'd1,
    A_NSEC = 2'd2,
    A_STAT = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    ACT_IRQ   = 2'b00,
    ACT_IRQ_B = 2'b01,
    ACT_START = 2'b10,
    ACT_STOP  = 2'b11
  } act_e;

  localparam logic [3:0] CMD_ARM_A = 4'b0010;
  localparam logic [3:0] CMD_ARM_B = 4'b0011;
  localparam int unsigned CMD_LSB = 0;
  localparam int unsigned ACT_LSB = 5;
  localparam int unsigned IEN_BIT = 8;
endpackage

// File: rtl/ptt_sync.sv
`timescale 1ns/1ps
module ptt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/ptt_regs.sv
`timescale 1ns/1ps
module ptt_regs
  import ptt_pkg::*;
#(
  parameter int unsigned DW           = 32,
  parameter int unsigned SEC_W        = 32,
  parameter int unsigned NS_W         = 31,
  parameter bit          ROLL_DIGITAL = 1'b1,
  parameter int unsigned NS_MAX       = 999_999_999,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             ack_tgl_i,
  input  logic             trig_tgl_i,
  output logic             req_tgl_o,
  output logic [SEC_W-1:0] tgt_sec_o,
  output logic [NS_W-1:0]  tgt_ns_o,
  output logic [1:0]       act_o,
  output logic             irq_o
);
  localparam logic [NS_W-1:0] NS_LIM = NS_W'(NS_MAX);

  logic             ack_s, trig_s, trig_d;
  logic             req_q, ien_q, stat_q;
  logic [1:0]       act_q;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;
  logic             busy, trig_pulse;
  logic             wr_ctrl, wr_sec, wr_ns, wr_stat, arm, ns_ok;
  logic [3:0]       cmd;

  ptt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_i), .q_o(ack_s));
  ptt_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trig_tgl_i), .q_o(trig_s));

  assign busy       = req_q ^ ack_s;
  assign trig_pulse = trig_s ^ trig_d;
  assign cmd        = wdata_i[CMD_LSB +: 4];

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL) && !busy;
  assign wr_sec  = wr_en_i && (addr_i == A_SEC)  && !busy;
  assign wr_ns   = wr_en_i && (addr_i == A_NSEC) && !busy;
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign arm     = wr_ctrl && ((cmd == CMD_ARM_A) || (cmd == CMD_ARM_B));
  assign ns_ok   = !ROLL_DIGITAL || (wdata_i[NS_W-1:0] <= NS_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_d <= 1'b0;
      req_q  <= 1'b0;
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
      act_q  <= 2'b00;
      sec_q  <= '0;
      ns_q   <= '0;
    end else begin
      trig_d <= trig_s;
      if (wr_ctrl) begin
        act_q <= wdata_i[ACT_LSB +: 2];
        ien_q <= wdata_i[IEN_BIT];
      end
      if (arm)            req_q <= ~req_q;
      if (wr_sec)         sec_q <= wdata_i[SEC_W-1:0];
      if (wr_ns && ns_ok) ns_q  <= wdata_i[NS_W-1:0];
      // set beats clear
      if (trig_pulse)                stat_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) stat_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[ACT_LSB +: 2] = act_q;
        rdata_o[IEN_BIT]      = ien_q;
      end
      A_SEC:  rdata_o[SEC_W-1:0] = sec_q;
      A_NSEC: begin
        rdata_o[NS_W-1:0] = ns_q;
        rdata_o[DW-1]     = busy;
      end
      default: rdata_o[0] = stat_q;
    endcase
  end

  assign req_tgl_o = req_q;
  assign tgt_sec_o = sec_q;
  assign tgt_ns_o  = ns_q;
  assign act_o     = act_q;
  assign irq_o     = stat_q & ien_q;

  // R6
  sec_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i && addr_i == A_SEC) |=> $stable(sec_q));
  // R4
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_en_i && addr_i == A_CTRL));
  // R3
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ROLL_DIGITAL || ns_q <= NS_LIM));
  // R10
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(trig_s != trig_d));
endmodule

// File: rtl/ptt_cmp.sv
`timescale 1ns/1ps
module ptt_cmp
  import ptt_pkg::*;
#(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned NS_W        = 31,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             ptp_clk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [NS_W-1:0]  tgt_ns_i,
  input  logic [1:0]       act_i,
  input  logic [SEC_W-1:0] ts_sec_i,
  input  logic [NS_W-1:0]  ts_ns_i,
  output logic             ack_tgl_o,
  output logic             trig_tgl_o,
  output logic             pps_o
);
  logic             req_s, req_d, load;
  logic [SEC_W-1:0] sh_sec;
  logic [NS_W-1:0]  sh_ns;
  logic [1:0]       sh_act;
  logic             armed_q, pps_q, trig_q;
  logic             reached, fire;

  ptt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(ptp_clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s));

  assign load    = req_s ^ req_d;
  // at-or-past: coarse increments can step over the exact value
  assign reached = (ts_sec_i > sh_sec) || ((ts_sec_i == sh_sec) && (ts_ns_i >= sh_ns));
  assign fire    = armed_q && reached;

  always_ff @(posedge ptp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d   <= 1'b0;
      sh_sec  <= '0;
      sh_ns   <= '0;
      sh_act  <= 2'b00;
      armed_q <= 1'b0;
      pps_q   <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      req_d <= req_s;
      if (fire) begin
        armed_q <= 1'b0;
        trig_q  <= ~trig_q;
        if (sh_act == ACT_START)     pps_q <= 1'b1;
        else if (sh_act == ACT_STOP) pps_q <= 1'b0;
      end
      // a fresh load overrides the disarm of the old target
      if (load) begin
        armed_q <= 1'b1;
        sh_sec  <= tgt_sec_i;
        sh_ns   <= tgt_ns_i;
        sh_act  <= act_i;
      end
    end
  end

  assign ack_tgl_o  = req_d;
  assign trig_tgl_o = trig_q;
  assign pps_o      = pps_q;

  // R8
  pps_cause_chk: assert property (@(posedge ptp_clk_i) disable iff (!rst_ni)
    (pps_q != $past(pps_q)) |-> $past(armed_q && reached));
  // R7
  fire_once_chk: assert property (@(posedge ptp_clk_i) disable iff (!rst_ni)
    ((trig_q != $past(trig_q)) && !$past(load)) |-> !armed_q);
  // R5
  ack_arm_chk: assert property (@(posedge ptp_clk_i) disable iff (!rst_ni)
    (req_d != $past(req_d)) |-> armed_q);
endmodule

// File: rtl/ptp_tgt_trigger.sv
`timescale 1ns/1ps
module ptp_tgt_trigger #(
  parameter int unsigned DW           = 32,
  parameter int unsigned SEC_W        = 32,
  parameter int unsigned NS_W         = 31,
  parameter bit          ROLL_DIGITAL = 1'b1,
  parameter int unsigned NS_MAX       = 999_999_999,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptp_clk_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [SEC_W-1:0] ts_sec_i,
  input  logic [NS_W-1:0]  ts_ns_i,
  output logic             pps_o,
  output logic             irq_o
);
  logic             req_tgl, ack_tgl, trig_tgl;
  logic [SEC_W-1:0] tgt_sec;
  logic [NS_W-1:0]  tgt_ns;
  logic [1:0]       act;

  ptt_regs #(
    .DW(DW), .SEC_W(SEC_W), .NS_W(NS_W), .ROLL_DIGITAL(ROLL_DIGITAL),
    .NS_MAX(NS_MAX), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_tgl_i(ack_tgl),
    .trig_tgl_i(trig_tgl), .req_tgl_o(req_tgl), .tgt_sec_o(tgt_sec),
    .tgt_ns_o(tgt_ns), .act_o(act), .irq_o(irq_o)
  );

  ptt_cmp #(
    .SEC_W(SEC_W), .NS_W(NS_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_cmp (
    .ptp_clk_i(ptp_clk_i), .rst_ni(rst_ni), .req_tgl_i(req_tgl),
    .tgt_sec_i(tgt_sec), .tgt_ns_i(tgt_ns), .act_i(act),
    .ts_sec_i(ts_sec_i), .ts_ns_i(ts_ns_i), .ack_tgl_o(ack_tgl),
    .trig_tgl_o(trig_tgl), .pps_o(pps_o)
  );
endmodule

// File: tb/ptp_tgt_trigger_bench.sv
`timescale 1ns/1ps
module ptp_tgt_trigger_bench;
  localparam int unsigned NS_MAX = 999_999_999;
  localparam longint      WRAP_H = 64'd100_000_000_000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] ts_sec = 32'd6;
  logic [30:0] ts_ns = 31'd999_990_000;
  logic        pps, irq;
  longint      ts_acc = 64'd99_999_000_000;
  int          step_h = 725;
  bit          ts_run = 1'b0;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  ptp_tgt_trigger u_ptp_tgt_trigger (
    .clk_i(clk), .rst_ni(rst_n), .ptp_clk_i(clk), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ts_sec_i(ts_sec), .ts_ns_i(ts_ns),
    .pps_o(pps), .irq_o(irq));

  // fractional-step timestamp source, hundredths of a ns
  always @(negedge clk) if (ts_run) begin
    ts_acc = ts_acc + step_h;
    if (ts_acc >= WRAP_H) begin
      ts_acc = ts_acc - WRAP_H;
      ts_sec <= ts_sec + 1;
    end
    ts_ns <= 31'(ts_acc / 100);
  end

  // reference model
  int          m_busy_cnt, m_load_cnt, m_irq_cnt;
  bit          m_armed, m_pps, m_stat, m_ien;
  logic [1:0]  m_act, p_act, s_act;
  logic [31:0] m_sec, p_sec, s_sec;
  logic [30:0] m_ns, p_ns, s_ns;

  always @(posedge clk or negedge rst_n) begin : model
    bit busy_old, set_now, do_load, hit;
    if (!rst_n) begin
      m_busy_cnt = 0; m_load_cnt = 0; m_irq_cnt = 0;
      m_armed = 0; m_pps = 0; m_stat = 0; m_ien = 0;
      m_act = 0; p_act = 0; s_act = 0;
      m_sec = 0; p_sec = 0; s_sec = 0;
      m_ns = 0; p_ns = 0; s_ns = 0;
    end else begin
      busy_old = (m_busy_cnt > 0);
      set_now = 0; do_load = 0;
      if (m_irq_cnt > 0) begin m_irq_cnt--; set_now = (m_irq_cnt == 0); end
      if (we && addr == 2'd3 && wdata[0]) m_stat = 0;
      if (set_now) m_stat = 1;
      if (m_load_cnt > 0) begin m_load_cnt--; do_load = (m_load_cnt == 0); end
      hit = (ts_sec > s_sec) || (ts_sec == s_sec && ts_ns >= s_ns);
      if (m_armed && hit) begin
        if (s_act == 2'b10) m_pps = 1;
        else if (s_act == 2'b11) m_pps = 0;
        m_irq_cnt = 3;
        m_armed = 0;
      end
      if (do_load) begin s_sec = p_sec; s_ns = p_ns; s_act = p_act; m_armed = 1; end
      if (m_busy_cnt > 0) m_busy_cnt--;
      if (we && !busy_old) begin
        case (addr)
          2'd0: begin
            m_act = wdata[6:5];
            m_ien = wdata[8];
            if (wdata[3:0] == 4'b0010 || wdata[3:0] == 4'b0011) begin
              m_busy_cnt = 5; m_load_cnt = 3;
              p_sec = m_sec; p_ns = m_ns; p_act = wdata[6:5];
            end
          end
          2'd1: m_sec = wdata;
          2'd2: if (wdata[30:0] <= 31'(NS_MAX)) m_ns = wdata[30:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return {23'd0, m_ien, 1'b0, m_act, 5'd0};
      2'd1:    return m_sec;
      2'd2:    return {(m_busy_cnt > 0), m_ns};
      default: return {31'd0, m_stat};
    endcase
  endfunction

  // per-cycle comparison
  always @(posedge clk) if (rst_n) begin
    #2;
    chk("R8 pps_o vs model", 64'(pps), 64'(m_pps));
    chk("R9 irq_o vs model", 64'(irq), 64'(m_stat & m_ien));
    case (addr)
      2'd0:    chk("R4 ctrl read vs model", 64'(rdata), 64'(exp_rd(addr)));
      2'd1:    chk("R2 sec read vs model", 64'(rdata), 64'(exp_rd(addr)));
      2'd2:    chk("R5 ns/busy read vs model", 64'(rdata), 64'(exp_rd(addr)));
      default: chk("R10 status read vs model", 64'(rdata), 64'(exp_rd(addr)));
    endcase
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
    @(negedge clk); addr = 2'd2;
  endtask

  task automatic wait_pps(bit v, int lim, output int waited);
    waited = 0;
    while (pps !== v && waited < lim) begin @(negedge clk); waited++; end
  endtask

  task automatic ahead(int unsigned dns, output logic [31:0] s, output logic [30:0] n);
    longint t;
    t = longint'(ts_ns) + dns;
    s = ts_sec;
    if (t > NS_MAX) begin t = t - (NS_MAX + 1); s = s + 1; end
    n = 31'(t);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog act hung exp finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, ts_s;
    logic [30:0] ts_n;
    int n, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", 64'(d), 64'd0);
    end
    chk("R1 reset pps_o", 64'(pps), 64'd0);
    chk("R1 reset irq_o", 64'(irq), 64'd0);
    ts_run = 1'b1;

    // R2 alarm registers
    wr(2'd1, 32'd6);
    wr(2'd2, 32'd999_999_999);
    rd(2'd1, d); chk("R2 sec readback", 64'(d), 64'd6);
    rd(2'd2, d); chk("R2 ns readback", 64'(d), 64'd999_999_999);

    // R3 out-of-range nanoseconds ignored
    wr(2'd2, 32'd1_000_000_000);
    rd(2'd2, d); chk("R3 ns above max ignored", 64'(d), 64'd999_999_999);
    wr(2'd2, 32'h7FFF_FFFF);
    rd(2'd2, d); chk("R3 ns all-ones ignored", 64'(d), 64'd999_999_999);

    // R4 non-arm command: no busy; command bits read 0
    wr(2'd0, 32'h0000_0105);
    #1 chk("R4 other cmd no busy", 64'(rdata[31]), 64'd0);
    rd(2'd0, d); chk("R4 ctrl readback", 64'(d), 64'h100);

    // R4/R5 arm with start action; alarm 6.999999999 is stepped over into second 7
    wr(2'd0, 32'h0000_0142);
    n = 0;
    #1;
    chk("R4 busy next cycle", 64'(rdata[31]), 64'd1);
    while (rdata[31] === 1'b1 && n < 50) begin n++; @(negedge clk); #1; end
    chk("R5 busy length", 64'(n), 64'd5);
    rd(2'd0, d); chk("R4 cmd reads zero", 64'(d), 64'h140);

    // R7/R8 start
    wait_pps(1'b1, 3000, w);
    chk("R8 start action raises pps_o", 64'(pps), 64'd1);
    chk("R7 fired in second 7", 64'(ts_sec), 64'd7);
    repeat (4) @(negedge clk);
    chk("R9 irq after trigger", 64'(irq), 64'd1);

    // R10 clear, R7 single fire
    wr(2'd3, 32'd1);
    chk("R10 clear drops irq", 64'(irq), 64'd0);
    repeat (50) @(negedge clk);
    chk("R7 no second fire", 64'(irq), 64'd0);

    // R8 stop action, R6 writes while busy ignored
    ahead(2000, ts_s, ts_n);
    wr(2'd1, ts_s);
    wr(2'd2, 32'(ts_n));
    wr(2'd0, 32'h0000_0162);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd5);
    repeat (6) @(negedge clk);
    rd(2'd1, d); chk("R6 sec write while busy ignored", 64'(d), 64'(ts_s));
    rd(2'd2, d); chk("R6 ns write while busy ignored", 64'(d), 64'(ts_n));
    chk("R6 no early trigger", 64'(pps), 64'd1);
    wait_pps(1'b0, 1000, w);
    chk("R8 stop action clears pps_o", 64'(pps), 64'd0);
    repeat (4) @(negedge clk);
    chk("R9 irq after stop trigger", 64'(irq), 64'd1);
    wr(2'd3, 32'd1);

    // R10 clear and set in the same cycle; action 00 leaves pps_o
    step_h = 333;
    ahead(500, ts_s, ts_n);
    wr(2'd1, ts_s);
    wr(2'd2, 32'(ts_n));
    wr(2'd0, 32'h0000_0103);
    n = 0;
    while (m_irq_cnt != 1 && n < 2000) begin @(negedge clk); n++; end
    we = 1'b1; addr = 2'd3; wdata = 32'd1;
    @(negedge clk); we = 1'b0; addr = 2'd2;
    #1 chk("R10 set wins over clear", 64'(irq), 64'd1);
    chk("R8 action 00 keeps pps_o", 64'(pps), 64'd0);
    wr(2'd3, 32'd1);
    chk("R10 later clear", 64'(irq), 64'd0);

    // R11 re-arm replaces pending alarm
    ahead(20000, ts_s, ts_n);
    wr(2'd1, ts_s);
    wr(2'd2, 32'(ts_n));
    wr(2'd0, 32'h0000_0142);
    repeat (8) @(negedge clk);
    ahead(1000, ts_s, ts_n);
    wr(2'd1, ts_s);
    wr(2'd2, 32'(ts_n));
    wr(2'd0, 32'h0000_0102);
    wait_pps(1'b1, 1500, w);
    chk("R11 new alarm fired first", 64'(pps), 64'd0);
    repeat (400) @(negedge clk);
    chk("R11 new action used", 64'(irq), 64'd1);
    wr(2'd3, 32'd1);
    repeat (7000) @(negedge clk);
    chk("R11 old alarm never fires", 64'(irq), 64'd0);
    chk("R11 old start action dropped", 64'(pps), 64'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule